// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the digital controller of an 8-bit successive-approximation converter with a serial host port. While chip select is low, the host clocks a control byte in on a data-in line. The byte chooses a channel, a clock mode, a reference and a power-down setting. The block then runs tracking, the bit trials and the serial read-back of the result. The analog parts stay outside. The block drives an 8-bit trial code to the DAC and reads back one comparator bit. The serial output is modelled as a data bit plus an output enable.

All serial inputs are sampled by a fast system clock. Serial-clock edges are found by comparing each sample with the one before it. Clock number 1 is the rising edge that clocks in the first 1 after chip select falls. Fall k is the falling edge that follows rise k.

The clock-mode bit picks the conversion clock:
- In external mode, the serial clock steps the trials. The first trial decision falls on the seventh clock after the control byte.
- In internal mode, a divided system clock steps the trials. The result is held in a register until the host shifts it out.

Top module: `sar_serial_ctrl`

## Requirements
- R1: `dout_oe` is high exactly while `cs_n` is low. While `cs_n` is high, `dout` reads 0.
- R2: A frame starts on the first serial-clock rise that samples `din`=1 while `cs_n` is low. Leading 0 bits are ignored.
- R3: The seven bits after the start bit are latched at rise 8. The order on the wire, first to last, is: `chan_sel[2]`, `chan_sel[1]`, `chan_sel[0]`, `int_mode` (1 = internal clock), `ref_sel`, `pd_sel[1]`, `pd_sel[0]`. These outputs hold until the next control byte completes.
- R4: `tracking` rises at fall 4 and drops when the conversion starts.
- R5: In external mode the conversion starts at fall 14. At that point `busy` goes high and `dac_code` becomes 0x80. Rises 15 to 22 decide bits 7 down to 0. A trial bit is kept when `cmp`=1 and cleared otherwise. The next lower bit is then set as the new trial.
- R6: In external mode, falls 16 to 23 present result bits 7 down to 0 on `dout`.
- R7: In internal mode the conversion starts at fall 8 with `dac_code`=0x80 and `busy` high. One trial is made every CONV_DIV system clocks. `busy` stays high until all eight trials are done.
- R8: In internal mode `dout` is 0 while the conversion runs, and serial-clock falls during that time have no effect. When the conversion completes, `dout` shows result bit 7. Each later fall shifts out the next lower bit.
- R9: After bit 0 has been shifted out, `dout` stays 0 until `cs_n` rises.
- R10: Raising `cs_n` mid-frame aborts the frame: `busy`, `tracking` and `dout` clear, and the block waits for a new start bit. If the abort comes before rise 8, the latched control outputs keep their old values.
- R11: After a conversion, `dac_code` holds the final result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial control data |
| cmp | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code | output | 8 | Current trial code or final result |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout |
| tracking | output | 1 | Sample/hold is tracking the input |
| busy | output | 1 | Conversion in progress |
| int_mode | output | 1 | Latched clock mode, 1 = internal |
| ref_sel | output | 1 | Latched reference selection |
| chan_sel | output | 3 | Latched channel selection |
| pd_sel | output | 2 | Latched power-down selection |

## Verification
The assertions assume that `sclk`, `din` and `cs_n` change only away from the rising edge of `clk`. They also assume that every serial-clock level lasts at least one system clock, so that each edge is seen exactly once, and that `cmp` settles within the cycle in which `dac_code` changes. The bench meets these assumptions as follows:
- It changes every serial input on the falling edge of `clk`.
- It holds each serial-clock level for three system clocks.
- It derives `cmp` combinationally from a modelled input voltage and the live trial code.

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
  parameter int CONV_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       din,
  input  logic       cmp,
  output logic [7:0] dac_code,
  output logic       dout,
  output logic       dout_oe,
  output logic       tracking,
  output logic       busy,
  output logic       int_mode,
  output logic       ref_sel,
  output logic [2:0] chan_sel,
  output logic [1:0] pd_sel
);
  localparam int DW = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_EXT, S_ICONV, S_IOUT} st_t;

  st_t           st;
  logic          sclk_q, dout_r;
  logic [4:0]    n;
  logic [5:0]    ctl;
  logic [7:0]    mask, sr;
  logic [DW-1:0] div;

  wire       rise  = sclk & ~sclk_q;
  wire       fall  = ~sclk & sclk_q;
  wire       tick  = (div == DW'(CONV_DIV - 1));
  wire       step  = busy & (((st == S_EXT) & rise) | ((st == S_ICONV) & tick));
  wire [7:0] nres  = cmp ? dac_code : (dac_code & ~mask);
  wire [7:0] nmask = mask >> 1;
  wire [6:0] full  = {ctl, din};
  wire [4:0] oidx  = 5'd23 - n;

  assign dout_oe = ~cs_n;
  assign dout    = dout_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sclk_q <= 1'b0; dout_r <= 1'b0; n <= '0; ctl <= '0;
      mask <= '0; sr <= '0; div <= '0; dac_code <= '0; tracking <= 1'b0;
      busy <= 1'b0; int_mode <= 1'b0; ref_sel <= 1'b0; chan_sel <= '0; pd_sel <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        st <= S_IDLE; n <= '0; tracking <= 1'b0; busy <= 1'b0;
        dout_r <= 1'b0; mask <= '0; div <= '0;
      end else begin
        if (step) begin
          dac_code <= nres | nmask;
          mask     <= nmask;
          if (nmask == 8'd0) begin
            busy <= 1'b0;
            if (st == S_ICONV) begin
              st     <= S_IOUT;
              dout_r <= nres[7];
              sr     <= {nres[6:0], 1'b0};
            end
          end
        end
        if (st == S_ICONV) div <= tick ? '0 : div + 1'b1;
        case (st)
          S_IDLE: if (rise && din) begin st <= S_CTRL; n <= 5'd1; end
          S_CTRL: begin
            if (rise) begin
              n   <= n + 5'd1;
              ctl <= full[5:0];
              if (n == 5'd7) begin
                chan_sel <= full[6:4];
                int_mode <= full[3];
                ref_sel  <= full[2];
                pd_sel   <= full[1:0];
              end
            end
            if (fall && n == 5'd4) tracking <= 1'b1;
            if (fall && n == 5'd8) begin
              if (int_mode) begin
                st <= S_ICONV; tracking <= 1'b0; busy <= 1'b1;
                dac_code <= 8'h80; mask <= 8'h80; div <= '0;
              end else begin
                st <= S_EXT;
              end
            end
          end
          S_EXT: begin
            if (rise && n != 5'd31) n <= n + 5'd1;
            if (fall) begin
              if (n == 5'd14) begin
                tracking <= 1'b0; busy <= 1'b1; dac_code <= 8'h80; mask <= 8'h80;
              end else if (n >= 5'd16 && n <= 5'd23) begin
                dout_r <= dac_code[oidx[2:0]];
              end else if (n > 5'd23) begin
                dout_r <= 1'b0;
              end
            end
          end
          S_IOUT: if (fall) begin dout_r <= sr[7]; sr <= {sr[6:0], 1'b0}; end
          default: ;
        endcase
      end
    end
  end

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!busy && !tracking && !dout));

  // R5
  conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_code == 8'h80 && !tracking));

  // R7
  trial_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(mask) == 1));

  // R4
  track_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && tracking));

  // R8
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int_mode) |-> !dout);
endmodule

// File: tb/sar_serial_ctrl_tb.sv
module sar_serial_ctrl_tb;
  localparam int DIV = 8;
  localparam int H   = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [7:0] vin = 8'h00;
  logic [7:0] dac_code;
  logic dout, dout_oe, tracking, busy, int_mode, ref_sel, cmp;
  logic [2:0] chan_sel;
  logic [1:0] pd_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign cmp = (vin >= dac_code);

  sar_serial_ctrl #(.CONV_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp(cmp),
    .dac_code(dac_code), .dout(dout), .dout_oe(dout_oe), .tracking(tracking),
    .busy(busy), .int_mode(int_mode), .ref_sel(ref_sel), .chan_sel(chan_sel),
    .pd_sel(pd_sel));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [7:0] v, input int idx);
    return (idx >= 0 && idx <= 7) ? v[idx] : 1'b0;
  endfunction

  task automatic wait_clk(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic sclk_cycle(input logic d);
    din = d; wait_clk(H);
    sclk = 1'b1; wait_clk(H);
    sclk = 1'b0; wait_clk(H);
  endtask

  task automatic run_frame(input bit im, input logic [2:0] ch, input bit rf,
                           input logic [1:0] pd, input logic [7:0] v, input int lz);
    logic [7:0] c;
    c = {1'b1, ch, im, rf, pd};
    vin = v;
    cs_n = 1'b0; wait_clk(2);
    check("R1 oe low-cs", dout_oe, 1);
    for (int i = 0; i < lz; i++) sclk_cycle(1'b0);
    for (int i = 7; i >= 0; i--) begin
      sclk_cycle(c[i]);
      if (i == 4) check("R4 track at fall 4", tracking, 1);
    end
    check("R3 fields", {chan_sel, int_mode, ref_sel, pd_sel}, c[6:0]);
    if (im) begin
      check("R7 busy at fall 8", busy, 1);
      check("R7 track off", tracking, 0);
      sclk_cycle(1'b0);
      check("R8 dout quiet in conv", dout, 0);
      wait_clk(8 * DIV + 2);
      check("R7 busy done", busy, 0);
      check("R11 result", dac_code, v);
      check("R8 msb", dout, v[7]);
      for (int k = 1; k <= 9; k++) begin
        sclk_cycle(1'b0);
        check(k <= 7 ? "R8 shift" : "R9 zeros", dout, exp_bit(v, 7 - k));
      end
    end else begin
      for (int f = 9; f <= 25; f++) begin
        sclk_cycle(1'b0);
        if (f == 13) check("R4 still tracking", tracking, 1);
        if (f == 14) begin
          check("R5 busy", busy, 1);
          check("R5 trial 0x80", dac_code, 8'h80);
        end
        if (f >= 16 && f <= 23) check("R6 bit", dout, exp_bit(v, 23 - f));
        if (f >= 24) check("R9 zeros", dout, 0);
      end
      check("R11 result", dac_code, v);
      check("R5 busy done", busy, 0);
    end
    cs_n = 1'b1; wait_clk(2);
    check("R1 oe high-cs", dout_oe, 0);
    check("R1 dout high-cs", dout, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 reset oe", dout_oe, 0);
    check("R1 reset busy", busy, 0);
    check("R3 reset fields", {chan_sel, int_mode, ref_sel, pd_sel}, 0);

    run_frame(1'b0, 3'd5, 1'b1, 2'd2, 8'hFF, 0);
    run_frame(1'b0, 3'd2, 1'b0, 2'd1, 8'h00, 2);
    run_frame(1'b1, 3'd7, 1'b0, 2'd3, 8'h80, 3);
    run_frame(1'b1, 3'd1, 1'b1, 2'd0, 8'h7F, 1);

    // R10: abort before rise 8 keeps the old fields
    cs_n = 1'b0; wait_clk(2);
    sclk_cycle(1'b1); sclk_cycle(1'b0); sclk_cycle(1'b0); sclk_cycle(1'b0); sclk_cycle(1'b0);
    check("R10 tracking before abort", tracking, 1);
    cs_n = 1'b1; wait_clk(2);
    check("R10 fields kept", {chan_sel, int_mode, ref_sel, pd_sel}, 7'b0011100);
    check("R10 tracking cleared", tracking, 0);

    // R10: abort in the middle of an external conversion
    vin = 8'hA5;
    cs_n = 1'b0; wait_clk(2);
    for (int i = 7; i >= 0; i--) sclk_cycle(i == 7 ? 1'b1 : 1'b0);
    for (int f = 9; f <= 17; f++) sclk_cycle(1'b0);
    check("R10 busy before abort", busy, 1);
    cs_n = 1'b1; wait_clk(2);
    check("R10 busy cleared", busy, 0);
    check("R10 dout cleared", dout, 0);
    check("R10 oe cleared", dout_oe, 0);

    // R2: zeros alone never start a frame
    cs_n = 1'b0; wait_clk(2);
    for (int i = 0; i < 12; i++) sclk_cycle(1'b0);
    check("R2 no start on zeros", tracking, 0);
    cs_n = 1'b1; wait_clk(2);

    for (int t = 0; t < 10; t++) begin
      r = $urandom;
      run_frame(r[0], r[3:1], r[4], r[6:5], r[15:8], int'(r[17:16]));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule